// File: doc/BRIEF.md
# Event Timestamp Capture Unit

This block freezes the current sub-second count, time of day and date into a set of holding registers at the moment an external event is seen. The event comes from one of two input pins, picked by a select input, and is recognised on a chosen edge (rising or falling) once it has passed through a two-flop synchronizer. A one-cycle pulse from a tamper detector can also cause a capture when the tamper-to-timestamp option is on. Nothing is captured while the timestamp enable is low.

A capture raises a capture flag. That flag appears only after a synchronization delay measured in prescaler ticks. A qualifying event that arrives while a capture is still in flight, or while the capture flag is set, raises an overflow flag on the next clock. Such an event leaves the earlier snapshot in place. Software clears either flag by writing 0 to it through a small write port, and a write of 1 leaves the flag as it is. If a clear of the capture flag lands in the same cycle as a new event, both flags end up set, so the event is never lost. The interrupt output is the capture flag gated by an interrupt enable.

Top module: `ts_capture_unit`

## Requirements
- R1: With `ts_en_i` low, neither pin edges nor tamper pulses change the snapshot or the capture flag.
- R2: With `edge_fall_i` = 0, a 0-to-1 change on the selected pin is accepted at the third rising clock edge after the change. The snapshot `{snap_subsec_o, snap_time_o, snap_date_o}` then holds the `now_*` inputs sampled at that edge.
- R3: The capture flag rises at the clock edge where the second `tick_i` pulse is sampled after the edge that accepted the event. Before that edge the flag stays 0.
- R4: An event arriving while a capture is in flight or `cap_flag_o` is 1 sets `ovf_flag_o` at the next edge and leaves the snapshot unchanged.
- R5: The overflow flag is set with no tick delay, so it can read 1 while `cap_flag_o` still reads 0.
- R6: If an event and a clear write with `clr_cap_i` = 0 meet in the same cycle while `cap_flag_o` is 1, both flags are 1 after that edge.
- R7: `irq_o` is 1 exactly when `cap_flag_o` is 1 and `irq_en_i` is 1, with no clock delay.
- R8: A one-cycle `tamper_evt_i` pulse causes a capture at the next edge only when `tamper_ts_en_i` = 1. With `tamper_ts_en_i` = 0 it is ignored.
- R9: `pin_sel_i` = 0 selects `evt_pins_i[0]` and 1 selects `evt_pins_i[1]`. Edges on the unselected pin are ignored.
- R10: On a cycle with `clr_wr_i` = 1, a flag whose data bit (`clr_cap_i`, `clr_ovf_i`) is 0 is cleared. A flag whose data bit is 1 is unchanged.
- R11: After synchronous reset both flags, `irq_o` and the snapshot are 0.
- R12: With `edge_fall_i` = 1 only a 1-to-0 change on the selected pin is accepted, with the same latency as R2. A 0-to-1 change is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-cycle prescaler tick enable |
| evt_pins_i | input | NUM_PINS (2) | Asynchronous event pins |
| pin_sel_i | input | SEL_W (1) | Index of the pin used for events |
| edge_fall_i | input | 1 | 0 = rising edge, 1 = falling edge |
| ts_en_i | input | 1 | Timestamp enable |
| irq_en_i | input | 1 | Interrupt enable |
| tamper_evt_i | input | 1 | Synchronous tamper detection pulse |
| tamper_ts_en_i | input | 1 | Let tamper pulses cause a capture |
| now_subsec_i | input | SUBSEC_W (16) | Live sub-second count |
| now_time_i | input | TIME_W (24) | Live time of day |
| now_date_i | input | DATE_W (24) | Live date |
| clr_wr_i | input | 1 | Flag write strobe |
| clr_cap_i | input | 1 | Write data for capture flag (0 clears) |
| clr_ovf_i | input | 1 | Write data for overflow flag (0 clears) |
| snap_subsec_o | output | SUBSEC_W (16) | Captured sub-second count |
| snap_time_o | output | TIME_W (24) | Captured time of day |
| snap_date_o | output | DATE_W (24) | Captured date |
| cap_flag_o | output | 1 | Capture flag |
| ovf_flag_o | output | 1 | Overflow flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The results of this block land at different times:
- A pin edge reaches the snapshot and the overflow flag at the third clock edge after the pin moves.
- A tamper pulse reaches them at the first edge.
- The capture flag waits for two further tick pulses.
- The interrupt follows the flag and enable with no clock delay.

The bench drives every input one time unit after a rising edge. Each table vector then waits four whole cycles before it reads the snapshot, which is beyond the three-edge pin latency. After that it gives exactly two single-cycle ticks before it reads the capture flag. The directed tests read the flags after each single tick and one cycle after each tamper pulse. This is how they show an overflow that is already visible while the capture flag is still 0.

// File: rtl/ts_pkg.sv
// Shared types for the timestamp capture unit.
// Assumes: nothing beyond a single system clock domain.
package ts_pkg;

    // Which transition of the selected pin counts as an event
    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } edge_mode_e;

endpackage

// File: rtl/ts_event_sync.sv
// Brings the asynchronous event pins into the clock domain through a
// two-flop synchronizer per pin, picks one pin by index and reports a
// one-cycle pulse on the configured edge of that pin.
// Assumes: select and edge mode are changed only while events are disabled,
// since a change can itself look like an edge.
module ts_event_sync #(
    parameter int NUM_PINS = 2,
    parameter int SEL_W    = 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PINS-1:0]   pins_i,
    input  logic [SEL_W-1:0]      sel_i,
    input  ts_pkg::edge_mode_e    mode_i,
    output logic                  edge_o
);

    logic [NUM_PINS-1:0] meta_q;
    logic [NUM_PINS-1:0] sync_q;
    logic                sel_lvl;
    logic                prev_q;

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin_sync
        // Two-stage synchronizer for one pin
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q[g] <= 1'b0;
                sync_q[g] <= 1'b0;
            end else begin
                meta_q[g] <= pins_i[g];
                sync_q[g] <= meta_q[g];
            end
        end
    end

    // Pick the synchronized level of the selected pin
    always_comb begin
        sel_lvl = 1'b0;
        for (int k = 0; k < NUM_PINS; k++) begin
            if (sel_i == SEL_W'(k)) sel_lvl = sync_q[k];
        end
    end

    // Remember the previous level of the selected pin
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sel_lvl;
    end

    // Edge pulse for the configured polarity
    always_comb begin
        if (mode_i == ts_pkg::EDGE_FALL) edge_o = prev_q & ~sel_lvl;
        else                             edge_o = sel_lvl & ~prev_q;
    end

endmodule

// File: rtl/ts_flag_ctrl.sv
// Owns the capture and overflow flags. An event that finds the unit idle
// is accepted and starts a wait of SYNC_TICKS prescaler ticks before the
// capture flag rises. An event that finds it busy sets the overflow flag
// at once. Software clears flags by writing 0; a racing event wins.
// Assumes: tick_i is a one-cycle enable; SYNC_TICKS >= 1.
module ts_flag_ctrl #(
    parameter int SYNC_TICKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    input  logic tick_i,
    input  logic clr_wr_i,
    input  logic clr_cap_i,
    input  logic clr_ovf_i,
    output logic accept_o,
    output logic busy_o,
    output logic cap_o,
    output logic ovf_o
);

    localparam int CNT_W = (SYNC_TICKS > 1) ? $clog2(SYNC_TICKS) : 1;

    logic             pend_q;
    logic [CNT_W-1:0] cnt_q;
    logic             cap_q;
    logic             ovf_q;
    logic             collide;
    logic             last_tick;

    // Busy covers both the in-flight wait and a set capture flag
    always_comb begin
        busy_o    = cap_q | pend_q;
        accept_o  = evt_i & ~busy_o;
        collide   = evt_i & busy_o;
        last_tick = pend_q & tick_i & (cnt_q == CNT_W'(SYNC_TICKS - 1));
    end

    // Tick counter for the synchronization delay of an accepted event
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            cnt_q  <= '0;
        end else if (accept_o) begin
            pend_q <= 1'b1;
            cnt_q  <= '0;
        end else if (last_tick) begin
            pend_q <= 1'b0;
            cnt_q  <= '0;
        end else if (pend_q && tick_i) begin
            cnt_q  <= cnt_q + CNT_W'(1);
        end
    end

    // Capture flag: set after the delay, cleared by a 0 write unless an event races it
    always_ff @(posedge clk) begin
        if (!rst_n)                                     cap_q <= 1'b0;
        else if (last_tick)                             cap_q <= 1'b1;
        else if (clr_wr_i && !clr_cap_i && !collide)    cap_q <= 1'b0;
    end

    // Overflow flag: set without delay on an event that finds the unit busy
    always_ff @(posedge clk) begin
        if (!rst_n)                      ovf_q <= 1'b0;
        else if (collide)                ovf_q <= 1'b1;
        else if (clr_wr_i && !clr_ovf_i) ovf_q <= 1'b0;
    end

    assign cap_o = cap_q;
    assign ovf_o = ovf_q;

    a_r3_cap_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cap_q) |-> $past(tick_i))
        else $error("R3: capture flag rose without a tick");

    a_r3_not_early: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |=> !cap_q)
        else $error("R3: capture flag set on acceptance");

    a_r4_overflow_on_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i && busy_o) |=> ovf_q)
        else $error("R4: overflow flag not set");

    a_r6_race_keeps_both: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i && cap_q && clr_wr_i && !clr_cap_i) |=> (cap_q && ovf_q))
        else $error("R6: racing clear lost a flag");

    a_r10_cap_falls_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cap_q) |-> $past(clr_wr_i && !clr_cap_i))
        else $error("R10: capture flag fell without a clear");

endmodule

// File: rtl/ts_snapshot_reg.sv
// Holding register for the captured sub-second, time and date values.
// Loads on a one-cycle strobe and keeps its value otherwise.
// Assumes: load_i is already qualified by the flag controller.
module ts_snapshot_reg #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] data_i,
    output logic [W-1:0] snap_o
);

    // Capture the live calendar value on an accepted event
    always_ff @(posedge clk) begin
        if (!rst_n)      snap_o <= '0;
        else if (load_i) snap_o <= data_i;
    end

endmodule

// File: rtl/ts_capture_unit.sv
// Top of the event timestamp capture unit. Combines the synchronized pin
// event and the tamper pulse, qualifies them with the enables, and drives
// the snapshot register and the flag controller.
// Assumes: tamper_evt_i is synchronous and one cycle wide; now_* are
// stable in the clock domain.
module ts_capture_unit #(
    parameter  int SUBSEC_W   = 16,
    parameter  int TIME_W     = 24,
    parameter  int DATE_W     = 24,
    parameter  int NUM_PINS   = 2,
    parameter  int SYNC_TICKS = 2,
    localparam int SEL_W      = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_i,
    input  logic [NUM_PINS-1:0] evt_pins_i,
    input  logic [SEL_W-1:0]    pin_sel_i,
    input  logic                edge_fall_i,
    input  logic                ts_en_i,
    input  logic                irq_en_i,
    input  logic                tamper_evt_i,
    input  logic                tamper_ts_en_i,
    input  logic [SUBSEC_W-1:0] now_subsec_i,
    input  logic [TIME_W-1:0]   now_time_i,
    input  logic [DATE_W-1:0]   now_date_i,
    input  logic                clr_wr_i,
    input  logic                clr_cap_i,
    input  logic                clr_ovf_i,
    output logic [SUBSEC_W-1:0] snap_subsec_o,
    output logic [TIME_W-1:0]   snap_time_o,
    output logic [DATE_W-1:0]   snap_date_o,
    output logic                cap_flag_o,
    output logic                ovf_flag_o,
    output logic                irq_o
);

    localparam int SNAP_W = SUBSEC_W + TIME_W + DATE_W;

    logic              pin_edge;
    logic              evt;
    logic              accept;
    logic              busy;
    logic [SNAP_W-1:0] snap;

    ts_event_sync #(
        .NUM_PINS (NUM_PINS),
        .SEL_W    (SEL_W)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pins_i (evt_pins_i),
        .sel_i  (pin_sel_i),
        .mode_i (ts_pkg::edge_mode_e'(edge_fall_i)),
        .edge_o (pin_edge)
    );

    // Qualify both event sources with the enables
    always_comb begin
        evt = ts_en_i & (pin_edge | (tamper_evt_i & tamper_ts_en_i));
    end

    ts_flag_ctrl #(
        .SYNC_TICKS (SYNC_TICKS)
    ) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (evt),
        .tick_i    (tick_i),
        .clr_wr_i  (clr_wr_i),
        .clr_cap_i (clr_cap_i),
        .clr_ovf_i (clr_ovf_i),
        .accept_o  (accept),
        .busy_o    (busy),
        .cap_o     (cap_flag_o),
        .ovf_o     (ovf_flag_o)
    );

    ts_snapshot_reg #(
        .W (SNAP_W)
    ) u_snap (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (accept),
        .data_i ({now_subsec_i, now_time_i, now_date_i}),
        .snap_o (snap)
    );

    assign {snap_subsec_o, snap_time_o, snap_date_o} = snap;

    // Interrupt follows the capture flag while enabled
    assign irq_o = cap_flag_o & irq_en_i;

    a_r1_disabled_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !ts_en_i |=> $stable(snap))
        else $error("R1: snapshot moved while disabled");

    a_r4_snapshot_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && busy) |=> $stable(snap))
        else $error("R4: snapshot overwritten on overflow");

endmodule

// File: tb/ts_capture_unit_test.sv
module ts_capture_unit_test;

    localparam logic [1:0] K_SEL = 2'd0, K_OTHER = 2'd1, K_TAMP = 2'd2, K_WRONG = 2'd3;

    typedef struct packed {
        logic       sel;
        logic       fall;
        logic [1:0] kind;
        logic       en;
        logic       tam;
        logic       exp;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, K_SEL,   1'b1, 1'b0, 1'b1},
        '{1'b1, 1'b0, K_SEL,   1'b1, 1'b0, 1'b1},
        '{1'b0, 1'b1, K_SEL,   1'b1, 1'b0, 1'b1},
        '{1'b1, 1'b1, K_SEL,   1'b1, 1'b0, 1'b1},
        '{1'b0, 1'b0, K_OTHER, 1'b1, 1'b0, 1'b0},
        '{1'b1, 1'b0, K_OTHER, 1'b1, 1'b0, 1'b0},
        '{1'b1, 1'b1, K_WRONG, 1'b1, 1'b0, 1'b0},
        '{1'b0, 1'b0, K_WRONG, 1'b1, 1'b0, 1'b0},
        '{1'b0, 1'b0, K_TAMP,  1'b1, 1'b1, 1'b1},
        '{1'b0, 1'b0, K_TAMP,  1'b1, 1'b0, 1'b0},
        '{1'b0, 1'b0, K_SEL,   1'b0, 1'b0, 1'b0},
        '{1'b0, 1'b0, K_TAMP,  1'b0, 1'b1, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [1:0]  pins = 2'b00;
    logic        sel = 1'b0;
    logic        fall = 1'b0;
    logic        ts_en = 1'b0;
    logic        irq_en = 1'b0;
    logic        tamper = 1'b0;
    logic        tam_en = 1'b0;
    logic [63:0] now = '0;
    logic        clr_wr = 1'b0;
    logic        clr_cap = 1'b1;
    logic        clr_ovf = 1'b1;
    logic [15:0] snap_sub;
    logic [23:0] snap_time;
    logic [23:0] snap_date;
    logic        cap, ovf, irq;

    int          n_vec = 0;
    int          n_bad = 0;
    logic [63:0] exp_snap = '0;

    always #5 clk = ~clk;

    ts_capture_unit uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .tick_i         (tick),
        .evt_pins_i     (pins),
        .pin_sel_i      (sel),
        .edge_fall_i    (fall),
        .ts_en_i        (ts_en),
        .irq_en_i       (irq_en),
        .tamper_evt_i   (tamper),
        .tamper_ts_en_i (tam_en),
        .now_subsec_i   (now[63:48]),
        .now_time_i     (now[47:24]),
        .now_date_i     (now[23:0]),
        .clr_wr_i       (clr_wr),
        .clr_cap_i      (clr_cap),
        .clr_ovf_i      (clr_ovf),
        .snap_subsec_o  (snap_sub),
        .snap_time_o    (snap_time),
        .snap_date_o    (snap_date),
        .cap_flag_o     (cap),
        .ovf_flag_o     (ovf),
        .irq_o          (irq)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic tick_pulse();
        tick = 1'b1;
        cyc(1);
        tick = 1'b0;
    endtask

    task automatic flag_write(input logic c, input logic o);
        clr_wr = 1'b1; clr_cap = c; clr_ovf = o;
        cyc(1);
        clr_wr = 1'b0; clr_cap = 1'b1; clr_ovf = 1'b1;
    endtask

    task automatic tamper_pulse();
        tamper = 1'b1;
        cyc(1);
        tamper = 1'b0;
    endtask

    function automatic string req_of(input vec_t v);
        if (!v.en) return "R1";
        case (v.kind)
            K_SEL:   return v.fall ? "R12" : "R2";
            K_OTHER: return "R9";
            K_TAMP:  return "R8";
            default: return "R12";
        endcase
    endfunction

    task automatic run_vec(input int i);
        vec_t v;
        logic idle;
        v = VECS[i];
        ts_en  = 1'b0;
        tam_en = v.tam;
        sel    = v.sel;
        fall   = v.fall;
        idle   = v.fall ^ (v.kind == K_WRONG);
        pins   = {2{idle}};
        now    = {16'(16'hA000 + i), 24'(i * 3 + 5), 24'(i * 7 + 9)};
        cyc(5);
        flag_write(1'b0, 1'b0);
        ts_en = v.en;
        case (v.kind)
            K_OTHER: pins[~sel] = ~idle;
            K_TAMP:  tamper_pulse();
            default: pins[sel] = ~idle;
        endcase
        cyc(4);
        if (v.exp) exp_snap = now;
        chk(req_of(v), {snap_sub, snap_time, snap_date}, exp_snap);
        tick_pulse();
        tick_pulse();
        chk(v.exp ? "R3" : req_of(v), 64'(cap), 64'(v.exp));
        chk("R4", 64'(ovf), 64'd0);
        ts_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [63:0] a_val;
        cyc(4);
        // R11: reset state
        chk("R11", 64'(cap), 64'd0);
        chk("R11", 64'(ovf), 64'd0);
        chk("R11", 64'(irq), 64'd0);
        chk("R11", {snap_sub, snap_time, snap_date}, 64'd0);
        rst_n = 1'b1;
        cyc(2);

        for (int i = 0; i < NV; i++) run_vec(i);

        // R3 / R5 / R4: second event during the tick wait
        ts_en = 1'b0; tam_en = 1'b1; irq_en = 1'b0;
        flag_write(1'b0, 1'b0);
        a_val = 64'h1234_5678_9ABC_DEF0;
        now = a_val;
        ts_en = 1'b1;
        tamper_pulse();
        chk("R8", {snap_sub, snap_time, snap_date}, a_val);
        now = 64'hFFFF_0000_FFFF_0000;
        tamper_pulse();
        chk("R5", 64'(ovf), 64'd1);
        chk("R5", 64'(cap), 64'd0);
        chk("R4", {snap_sub, snap_time, snap_date}, a_val);
        tick_pulse();
        chk("R3", 64'(cap), 64'd0);
        tick_pulse();
        chk("R3", 64'(cap), 64'd1);

        // R7: interrupt gating
        irq_en = 1'b1; #1;
        chk("R7", 64'(irq), 64'd1);
        irq_en = 1'b0; #1;
        chk("R7", 64'(irq), 64'd0);
        irq_en = 1'b1;

        // R10: writing 1 keeps, writing 0 clears
        flag_write(1'b1, 1'b1);
        chk("R10", 64'(cap), 64'd1);
        chk("R10", 64'(ovf), 64'd1);
        flag_write(1'b1, 1'b0);
        chk("R10", 64'(ovf), 64'd0);
        chk("R10", 64'(cap), 64'd1);

        // R4: event while capture flag set
        tamper_pulse();
        chk("R4", 64'(ovf), 64'd1);
        chk("R4", {snap_sub, snap_time, snap_date}, a_val);
        flag_write(1'b1, 1'b0);

        // R6: clear racing a new event
        tamper = 1'b1; clr_wr = 1'b1; clr_cap = 1'b0; clr_ovf = 1'b1;
        cyc(1);
        tamper = 1'b0; clr_wr = 1'b0; clr_cap = 1'b1;
        chk("R6", 64'(cap), 64'd1);
        chk("R6", 64'(ovf), 64'd1);
        chk("R6", {snap_sub, snap_time, snap_date}, a_val);

        // R10 / R7: plain clear drops both flags and the interrupt
        flag_write(1'b0, 1'b0);
        chk("R10", 64'(cap), 64'd0);
        chk("R10", 64'(ovf), 64'd0);
        chk("R7", 64'(irq), 64'd0);

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule